// File: doc/BRIEF.md
# Edge-Triggered Secondary Interrupt Controller

This block collects up to 24 single-bit event sources and turns selected edges on them into latched interrupt status. Each source is brought into the clock domain through two flops. A per-source two-bit edge selector picks a rising edge, a falling edge, both, or neither. Every detected edge sets the source's bit in two separate status banks, one for each interrupt output. Each output also has its own mask bank, so two different consumers can take interest in different subsets of the same sources.

Software reaches the registers through a byte-wide register bus. A control bit picks how status is acknowledged. In one mode, reading a status byte clears the bits that the read returned. In the other mode, software clears a bit by writing a 1 to it.

Top module: `sec_irq_ctrl`

Register map (6-bit byte address): control at 0x00, edge-select bytes from 0x08, line A status from 0x10, line A mask from 0x18, line B status from 0x20, line B mask from 0x28. Status and mask banks each use ceil(N_SRC/8) bytes, and edge select uses ceil(2*N_SRC/8) bytes.

## Requirements
- R1: After reset, the control byte (0x00), every edge-select byte and every status byte read 0x00, every mask byte reads 0xFF, and both `irq_a` and `irq_b` are low.
- R2: The selector for source i sits in edge-select byte 0x08 + i/4, at bits [2*(i%4)+1 : 2*(i%4)]. The upper bit arms rising-edge detection and the lower bit arms falling-edge detection. The value 11 arms both edges, and 00 never produces an event. The edge-select bytes read back as written.
- R3: A detected edge sets the source's status bit in both the line A and the line B banks, whatever the masks hold. The bit is set within six clock cycles of the input change.
- R4: Status and mask banks are little-endian. Source i is bit i%8 of byte base + i/8.
- R5: Each interrupt output is a registered OR over all sources of (status AND NOT mask) for its own bank. A mask bit of 1 blocks the source. A mask write changes the output on the following clock, and the two lines do not affect each other.
- R6: With control bit 0 clear, writing a 1 to a status bit clears it and writing a 0 leaves it unchanged.
- R7: With control bit 0 set, a read of a status byte clears exactly the bits that the read returned, and only in the bank that was read. Writes to status bytes are ignored in this mode.
- R8: If a new edge and a clear reach the same status bit in the same cycle, the bit ends up set.
- R9: Read data is loaded on the clock edge that samples `rd_en` and holds until the next read. An address outside the map reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | N_SRC | Asynchronous event sources |
| addr | input | 6 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |

## Verification
The checker assumes that sources are low while reset is held. It also assumes that bus strobes are single-cycle pulses whose address and data are stable around the sampling edge. The bench changes sources and bus signals only on the falling clock edge, and it keeps every source level for at least six cycles before the next change. The one exception is the priority test, which deliberately lines up a write-one-to-clear with the cycle in which the synchronised edge lands. That test counts the synchronizer stages to find the right cycle.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_EDGE  = 6'h08;
    localparam logic [ADDR_W-1:0] ADR_STA_A = 6'h10;
    localparam logic [ADDR_W-1:0] ADR_MSK_A = 6'h18;
    localparam logic [ADDR_W-1:0] ADR_STA_B = 6'h20;
    localparam logic [ADDR_W-1:0] ADR_MSK_B = 6'h28;
    localparam int CTRL_COR_BIT = 0;
endpackage

// File: rtl/sic_edge_detect.sv
module sic_edge_detect #(
    parameter int N = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   src,
    input  logic [2*N-1:0] esel,
    output logic [N-1:0]   ev
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= src;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        logic rise_w, fall_w;
        assign rise_w = sync_q[i] & ~prev_q[i];
        assign fall_w = ~sync_q[i] & prev_q[i];
        assign ev[i]  = (esel[2*i+1] & rise_w) | (esel[2*i] & fall_w);
    end
endmodule

// File: rtl/sic_bank.sv
module sic_bank #(
    parameter int N = 24,
    localparam int NB = (N + 7) / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  ev,
    input  logic [N-1:0]  clr,
    input  logic [NB-1:0] msk_we,
    input  logic [7:0]    wdata,
    output logic [N-1:0]  status,
    output logic [N-1:0]  mask,
    output logic          irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= (status & ~clr) | ev;
            irq    <= |(status & ~mask);
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask[i] <= 1'b1;
            else if (msk_we[i/8])
                mask[i] <= wdata[i%8];
        end
    end
endmodule

// File: rtl/sic_regbus.sv
module sic_regbus
    import sic_pkg::*;
#(
    parameter int N = 24,
    localparam int NB = (N + 7) / 8,
    localparam int EB = (2 * N + 7) / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic              rd_en,
    input  logic [N-1:0]      status_a,
    input  logic [N-1:0]      status_b,
    input  logic [N-1:0]      mask_a,
    input  logic [N-1:0]      mask_b,
    output logic              cor,
    output logic [2*N-1:0]    esel,
    output logic [N-1:0]      clr_a,
    output logic [N-1:0]      clr_b,
    output logic [NB-1:0]     mska_we,
    output logic [NB-1:0]     mskb_we,
    output logic [7:0]        rd_data
);
    localparam int PW = 8 * NB;
    localparam int EW = 8 * EB;

    logic [PW-1:0] sa_p, sb_p, ma_p, mb_p;
    logic [EW-1:0] es_p;
    logic [7:0]    rmux;

    assign sa_p = PW'(status_a);
    assign sb_p = PW'(status_b);
    assign ma_p = PW'(mask_a);
    assign mb_p = PW'(mask_b);
    assign es_p = EW'(esel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cor <= 1'b0;
        else if (wr_en && addr == ADR_CTRL)
            cor <= wdata[CTRL_COR_BIT];
    end

    for (genvar j = 0; j < 2 * N; j++) begin : g_esel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                esel[j] <= 1'b0;
            else if (wr_en && addr == ADR_EDGE + ADDR_W'(j / 8))
                esel[j] <= wdata[j % 8];
        end
    end

    for (genvar k = 0; k < NB; k++) begin : g_mwe
        assign mska_we[k] = wr_en && addr == ADR_MSK_A + ADDR_W'(k);
        assign mskb_we[k] = wr_en && addr == ADR_MSK_B + ADDR_W'(k);
    end

    for (genvar i = 0; i < N; i++) begin : g_clr
        logic hit_a, hit_b;
        assign hit_a = addr == ADR_STA_A + ADDR_W'(i / 8);
        assign hit_b = addr == ADR_STA_B + ADDR_W'(i / 8);
        assign clr_a[i] = hit_a && ((wr_en && !cor && wdata[i % 8]) ||
                                    (rd_en && cor && status_a[i]));
        assign clr_b[i] = hit_b && ((wr_en && !cor && wdata[i % 8]) ||
                                    (rd_en && cor && status_b[i]));
    end

    always_comb begin
        rmux = 8'h00;
        if (addr == ADR_CTRL)
            rmux = {7'b0, cor};
        for (int e = 0; e < EB; e++)
            if (addr == ADR_EDGE + ADDR_W'(e))
                rmux = es_p[8*e +: 8];
        for (int k = 0; k < NB; k++) begin
            if (addr == ADR_STA_A + ADDR_W'(k)) rmux = sa_p[8*k +: 8];
            if (addr == ADR_MSK_A + ADDR_W'(k)) rmux = ma_p[8*k +: 8];
            if (addr == ADR_STA_B + ADDR_W'(k)) rmux = sb_p[8*k +: 8];
            if (addr == ADR_MSK_B + ADDR_W'(k)) rmux = mb_p[8*k +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= 8'h00;
        else if (rd_en)
            rd_data <= rmux;
    end
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
    import sic_pkg::*;
#(
    parameter int N_SRC = 24,
    localparam int NB = (N_SRC + 7) / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic              irq_a,
    output logic              irq_b
);
    logic [N_SRC-1:0]   ev, status_a, status_b, mask_a, mask_b, clr_a, clr_b;
    logic [2*N_SRC-1:0] esel;
    logic [NB-1:0]      mska_we, mskb_we;
    logic               cor;

    sic_edge_detect #(.N(N_SRC)) u_edge (
        .clk(clk), .rst_n(rst_n), .src(src), .esel(esel), .ev(ev)
    );

    sic_regbus #(.N(N_SRC)) u_bus (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .status_a(status_a), .status_b(status_b),
        .mask_a(mask_a), .mask_b(mask_b), .cor(cor), .esel(esel),
        .clr_a(clr_a), .clr_b(clr_b), .mska_we(mska_we), .mskb_we(mskb_we),
        .rd_data(rd_data)
    );

    sic_bank #(.N(N_SRC)) u_bank_a (
        .clk(clk), .rst_n(rst_n), .ev(ev), .clr(clr_a), .msk_we(mska_we),
        .wdata(wdata), .status(status_a), .mask(mask_a), .irq(irq_a)
    );

    sic_bank #(.N(N_SRC)) u_bank_b (
        .clk(clk), .rst_n(rst_n), .ev(ev), .clr(clr_b), .msk_we(mskb_we),
        .wdata(wdata), .status(status_b), .mask(mask_b), .irq(irq_b)
    );
endmodule

// File: rtl/sic_checker.sv
module sic_checker
    import sic_pkg::*;
#(
    parameter int N = 24,
    localparam int NB = (N + 7) / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wdata0,
    input logic              cor,
    input logic [N-1:0]      ev,
    input logic [N-1:0]      status_a,
    input logic [N-1:0]      mask_a,
    input logic              irq_a
);
    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == '0) |=> ((status_a & ~$past(status_a)) == '0));

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || addr < ADR_MSK_A || addr >= ADR_MSK_A + ADDR_W'(NB))
        |=> $stable(mask_a));

    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_a == {N{1'b1}}) |=> !irq_a);

    assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cor && addr == ADR_STA_A && wdata0 && !ev[0]) |=> !status_a[0]);

    assert_cor_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cor && addr == ADR_STA_A && !ev[0]) |=> !status_a[0]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev[0] |=> status_a[0]);
endmodule

bind sec_irq_ctrl sic_checker #(.N(N_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata0(wdata[0]), .cor(cor), .ev(ev), .status_a(status_a),
    .mask_a(mask_a), .irq_a(irq_a)
);

// File: tb/sim_sec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sec_irq_ctrl;
    import sic_pkg::*;

    localparam int N = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic [5:0] addr = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;
    logic irq_a, irq_b;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sec_irq_ctrl #(.N_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .src(src), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rd_en(rd_en), .rd_data(rd_data), .irq_a(irq_a), .irq_b(irq_b)
    );

    // {source index, edge select (rise,fall), 1 = rising transition, status expected}
    localparam logic [8:0] VEC [0:7] = '{
        {5'd0,  2'b10, 1'b1, 1'b1},
        {5'd0,  2'b10, 1'b0, 1'b0},
        {5'd5,  2'b01, 1'b0, 1'b1},
        {5'd5,  2'b01, 1'b1, 1'b0},
        {5'd13, 2'b11, 1'b1, 1'b1},
        {5'd13, 2'b11, 1'b0, 1'b1},
        {5'd22, 2'b00, 1'b1, 1'b0},
        {5'd23, 2'b11, 1'b0, 1'b1}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        check("R1 irq_a", {7'b0, irq_a}, 8'h00);
        check("R1 irq_b", {7'b0, irq_b}, 8'h00);
        rd(ADR_CTRL, d);        check("R1 ctrl", d, 8'h00);
        rd(ADR_EDGE + 6'd5, d); check("R1 edge", d, 8'h00);
        rd(ADR_STA_A, d);       check("R1 status", d, 8'h00);
        rd(ADR_MSK_A, d);       check("R1 mask a", d, 8'hFF);
        rd(ADR_MSK_B + 6'd2, d); check("R1 mask b", d, 8'hFF);

        // R9 unmapped address and R2 readback
        rd(6'h3F, d); check("R9 unmapped", d, 8'h00);
        wr(ADR_EDGE + 6'd3, 8'h96);
        rd(ADR_EDGE + 6'd3, d); check("R2 readback", d, 8'h96);
        wr(ADR_EDGE + 6'd3, 8'h00);

        // R2 R4 R3 vector walk
        for (int v = 0; v < 8; v++) begin
            int idx, by, bt;
            logic [1:0] sel;
            logic dir, ex;
            {idx, sel, dir, ex} = {27'd0, VEC[v]};
            idx = int'(VEC[v][8:4]);
            by = idx / 8; bt = idx % 8;
            wr(ADR_EDGE + 6'(idx / 4), 8'h00);
            src[idx] = ~dir;
            tick(6);
            wr(ADR_EDGE + 6'(idx / 4), 8'({sel} << (2 * (idx % 4))));
            wr(ADR_STA_A + 6'(by), 8'hFF);
            wr(ADR_STA_B + 6'(by), 8'hFF);
            src[idx] = dir;
            tick(6);
            rd(ADR_STA_A + 6'(by), d);
            check($sformatf("R2 R4 vec%0d line a", v), d, 8'(ex) << bt);
            rd(ADR_STA_B + 6'(by), d);
            check($sformatf("R3 vec%0d line b", v), d, 8'(ex) << bt);
            wr(ADR_EDGE + 6'(idx / 4), 8'h00);
            src[idx] = 1'b0;
            tick(6);
        end
        for (int k = 0; k < 3; k++) begin
            wr(ADR_STA_A + 6'(k), 8'hFF);
            wr(ADR_STA_B + 6'(k), 8'hFF);
        end

        // R3 R5 masking and line independence (source 9: byte 1 bit 1)
        wr(ADR_EDGE + 6'd2, 8'h08);
        src[9] = 1'b1;
        tick(6);
        check("R5 masked irq_a", {7'b0, irq_a}, 8'h00);
        rd(ADR_STA_A + 6'd1, d); check("R3 set while masked", d, 8'h02);
        wr(ADR_MSK_A + 6'd1, 8'hFD);
        tick(1);
        check("R5 unmasked irq_a", {7'b0, irq_a}, 8'h01);
        check("R5 irq_b independent", {7'b0, irq_b}, 8'h00);
        rd(ADR_MSK_A + 6'd1, d); check("R5 mask readback", d, 8'hFD);

        // R6 write-one-to-clear
        wr(ADR_STA_A + 6'd1, 8'h00);
        tick(1);
        check("R6 zero write keeps irq", {7'b0, irq_a}, 8'h01);
        rd(ADR_STA_A + 6'd1, d); check("R6 zero write keeps bit", d, 8'h02);
        wr(ADR_STA_A + 6'd1, 8'h02);
        tick(1);
        check("R6 irq after clear", {7'b0, irq_a}, 8'h00);
        rd(ADR_STA_A + 6'd1, d); check("R6 bit cleared", d, 8'h00);
        rd(ADR_STA_B + 6'd1, d); check("R6 other bank kept", d, 8'h02);
        wr(ADR_STA_B + 6'd1, 8'h02);

        // R7 clear-on-read
        wr(ADR_CTRL, 8'h01);
        rd(ADR_CTRL, d); check("R7 ctrl readback", d, 8'h01);
        src[9] = 1'b0; tick(6);
        src[9] = 1'b1; tick(6);
        check("R7 irq set", {7'b0, irq_a}, 8'h01);
        wr(ADR_STA_A + 6'd1, 8'hFF);
        tick(1);
        check("R7 write ignored", {7'b0, irq_a}, 8'h01);
        rd(ADR_STA_A + 6'd1, d); check("R7 first read", d, 8'h02);
        rd(ADR_STA_A + 6'd1, d); check("R7 second read", d, 8'h00);
        check("R7 irq cleared", {7'b0, irq_a}, 8'h00);
        rd(ADR_STA_B + 6'd1, d); check("R7 bank b untouched", d, 8'h02);
        rd(ADR_STA_B + 6'd1, d); check("R7 bank b cleared by own read", d, 8'h00);

        // R9 read data holds between reads
        wr(ADR_MSK_B, 8'h55);
        tick(2);
        check("R9 rd_data hold", rd_data, 8'h00);

        // R8 set wins over a same-cycle clear (source 0, both edges)
        wr(ADR_CTRL, 8'h00);
        wr(ADR_EDGE, 8'h03);
        wr(ADR_STA_A, 8'hFF);
        src[0] = 1'b1;
        tick(6);
        @(negedge clk); src[0] = 1'b0;
        @(negedge clk);
        @(negedge clk); addr = ADR_STA_A; wdata = 8'h01; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        tick(1);
        rd(ADR_STA_A, d); check("R8 set wins", d, 8'h01);
        wr(ADR_STA_A, 8'h01);
        rd(ADR_STA_A, d); check("R8 later clear", d, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule